// File: doc/BRIEF.md
# Mixed-Precision Hardwired Decision Tree Classifier

This block classifies one feature vector per clock with a decision tree whose shape, feature selections, thresholds and per-node bit widths are all fixed when the block is built. Each feature is an unsigned 8-bit fraction, the value divided by 256, so it lies in the range zero to just below one. Every internal node looks at one feature. It keeps only the upper bits of that feature, at a width chosen for that node, and compares them with a constant given at the same width. Every node is evaluated in the same cycle, with no sequential walk. Path logic then marks the single leaf that the sample reaches, and the class label of that leaf is produced.

A sample is offered by raising `in_valid` with the features on `in_feat`. On that clock edge the leaf and class are registered, and `out_valid` rises for one cycle. A small two-state control machine owns `out_valid`. In state ST_EMPTY an edge with `in_valid` high takes the LOAD transition to ST_FULL, and an edge with it low takes the IDLE transition and stays in ST_EMPTY. In state ST_FULL an edge with `in_valid` high takes the STREAM transition and stays in ST_FULL, and an edge with it low takes the DRAIN transition back to ST_EMPTY. Reset forces ST_EMPTY.

The default tree is listed below. Each node compares feature bits [7 : 8-P] against T. Here "n" is an internal node and "L" is a leaf, written as leaf(class).

| Node | Feature | P | T | Left (<= T) | Right (> T) |
|---|---|---|---|---|---|
| n0 | 0 | 8 | 100 | n1 | n2 |
| n1 | 1 | 4 | 9 | L0(0) | n3 |
| n2 | 2 | 6 | 40 | n4 | L1(1) |
| n3 | 3 | 3 | 2 | L2(2) | L3(3) |
| n4 | 0 | 7 | 60 | L4(1) | n5 |
| n5 | 3 | 2 | 1 | L5(0) | L6(2) |

Top module: `dtree_classifier`

## Requirements
- R1: Feature k occupies bits in_feat[8k+7 : 8k] as an unsigned 8-bit fraction, and there are four features (k = 0..3).
- R2: A node keeps the P most significant bits of its feature and sends the sample left when that truncated value is less than or equal to its constant threshold T, so a truncated value equal to T goes left; otherwise it goes right.
- R3: Each node uses its own width P and threshold T exactly as given in the node table, so two features that differ only below a node's kept bits make the same decision at that node.
- R4: The registered leaf is the one reached by walking the table from n0, and out_leaf bit j is set for leaf Lj.
- R5: While out_valid is high, exactly one bit of out_leaf is set.
- R6: out_class equals the class of the selected leaf: L0→0, L1→1, L2→2, L3→3, L4→1, L5→0, L6→2.
- R7: A clock edge with in_valid high makes out_valid high after that edge. An edge with in_valid low makes it low.
- R8: An edge with in_valid low leaves out_class and out_leaf unchanged.
- R9: Synchronous reset clears out_valid, out_class and out_leaf to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on in_feat |
| in_feat | input | 32 | Four packed 8-bit unsigned features |
| out_valid | output | 1 | Result registered from a sample on the previous edge |
| out_class | output | 2 | Class label of the reached leaf |
| out_leaf | output | 7 | One-hot index of the reached leaf |

## Verification
The properties assume that in_valid is always a known level and that in_feat carries no unknown bits on an edge where in_valid is high. The one-leaf property relies on that. The stimulus drives every input from reset onward and changes inputs only on the falling clock edge. It mixes random feature vectors and random gaps in in_valid with directed vectors that place a truncated feature exactly on each node's threshold and one step above it.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int DEF_NUM_FEAT   = 4;
    localparam int DEF_FEAT_W     = 8;
    localparam int DEF_NUM_NODES  = 6;
    localparam int DEF_NUM_LEAVES = 7;
    localparam int DEF_CLASS_W    = 2;

    // Child links: values below DEF_NUM_NODES name an internal node,
    // values from DEF_NUM_NODES upward name leaf (value - DEF_NUM_NODES).
    localparam int LEAF_BASE = DEF_NUM_NODES;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } vstate_t;

    function automatic int node_feat(input int n);
        int r;
        unique case (n)
            0: r = 0;
            1: r = 1;
            2: r = 2;
            3: r = 3;
            4: r = 0;
            5: r = 3;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic int node_prec(input int n);
        int r;
        unique case (n)
            0: r = 8;
            1: r = 4;
            2: r = 6;
            3: r = 3;
            4: r = 7;
            5: r = 2;
            default: r = 8;
        endcase
        return r;
    endfunction

    function automatic int node_thr(input int n);
        int r;
        unique case (n)
            0: r = 100;
            1: r = 9;
            2: r = 40;
            3: r = 2;
            4: r = 60;
            5: r = 1;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic int node_left(input int n);
        int r;
        unique case (n)
            0: r = 1;
            1: r = LEAF_BASE + 0;
            2: r = 4;
            3: r = LEAF_BASE + 2;
            4: r = LEAF_BASE + 4;
            5: r = LEAF_BASE + 5;
            default: r = LEAF_BASE;
        endcase
        return r;
    endfunction

    function automatic int node_right(input int n);
        int r;
        unique case (n)
            0: r = 2;
            1: r = 3;
            2: r = LEAF_BASE + 1;
            3: r = LEAF_BASE + 3;
            4: r = 5;
            5: r = LEAF_BASE + 6;
            default: r = LEAF_BASE;
        endcase
        return r;
    endfunction

    function automatic int leaf_class(input int l);
        int r;
        unique case (l)
            0: r = 0;
            1: r = 1;
            2: r = 2;
            3: r = 3;
            4: r = 1;
            5: r = 0;
            6: r = 2;
            default: r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dt_node_cmp.sv
module dt_node_cmp #(
    parameter int FEAT_W = 8,
    parameter int PREC   = 8,
    parameter int THR    = 0
) (
    input  logic [FEAT_W-1:0] feat,
    output logic              go_left
);
    localparam int KEEP = (PREC > FEAT_W) ? FEAT_W : ((PREC < 1) ? 1 : PREC);
    localparam logic [KEEP-1:0] THR_K = KEEP'(THR);

    logic [KEEP-1:0] feat_k;

    generate
        if (KEEP == FEAT_W) begin : g_full
            assign feat_k = feat;
        end else begin : g_trunc
            assign feat_k = feat[FEAT_W-1 -: KEEP];
        end
    endgenerate

    // R2: ties take the left branch
    assign go_left = (feat_k <= THR_K);
endmodule

// File: rtl/dt_leaf_resolve.sv
module dt_leaf_resolve #(
    parameter int NUM_NODES  = dt_pkg::DEF_NUM_NODES,
    parameter int NUM_LEAVES = dt_pkg::DEF_NUM_LEAVES,
    parameter int CLASS_W    = dt_pkg::DEF_CLASS_W
) (
    input  logic [NUM_NODES-1:0]  go_left,
    output logic [NUM_LEAVES-1:0] leaf_hit,
    output logic [CLASS_W-1:0]    leaf_cls
);
    logic [NUM_NODES-1:0] reach;

    // Parents precede children in the table, so one ordered pass
    // forms the AND of every decision on each root-to-leaf path.
    always_comb begin
        reach    = '0;
        leaf_hit = '0;
        reach[0] = 1'b1;
        for (int n = 0; n < NUM_NODES; n++) begin
            if (dt_pkg::node_left(n) < NUM_NODES)
                reach[dt_pkg::node_left(n)] = reach[n] & go_left[n];
            else
                leaf_hit[dt_pkg::node_left(n) - NUM_NODES] = reach[n] & go_left[n];
            if (dt_pkg::node_right(n) < NUM_NODES)
                reach[dt_pkg::node_right(n)] = reach[n] & ~go_left[n];
            else
                leaf_hit[dt_pkg::node_right(n) - NUM_NODES] = reach[n] & ~go_left[n];
        end
    end

    always_comb begin
        leaf_cls = '0;
        for (int l = 0; l < NUM_LEAVES; l++) begin
            if (leaf_hit[l])
                leaf_cls = leaf_cls | CLASS_W'(dt_pkg::leaf_class(l));
        end
    end
endmodule

// File: rtl/dt_valid_fsm.sv
module dt_valid_fsm (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic load_en,
    output logic out_valid
);
    import dt_pkg::*;

    vstate_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_EMPTY;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: st_d = in_valid ? ST_FULL : ST_EMPTY;  // LOAD / IDLE
            ST_FULL:  st_d = in_valid ? ST_FULL : ST_EMPTY;  // STREAM / DRAIN
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        load_en   = in_valid;
        out_valid = (st_q == ST_FULL);
    end
endmodule

// File: rtl/dtree_classifier.sv
module dtree_classifier #(
    parameter int NUM_FEAT   = dt_pkg::DEF_NUM_FEAT,
    parameter int FEAT_W     = dt_pkg::DEF_FEAT_W,
    parameter int NUM_NODES  = dt_pkg::DEF_NUM_NODES,
    parameter int NUM_LEAVES = dt_pkg::DEF_NUM_LEAVES,
    parameter int CLASS_W    = dt_pkg::DEF_CLASS_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NUM_FEAT*FEAT_W-1:0] in_feat,
    output logic                       out_valid,
    output logic [CLASS_W-1:0]         out_class,
    output logic [NUM_LEAVES-1:0]      out_leaf
);
    logic [NUM_NODES-1:0]  go_left;
    logic [NUM_LEAVES-1:0] leaf_hit;
    logic [CLASS_W-1:0]    leaf_cls;
    logic                  load_en;

    generate
        for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
            localparam int FI = dt_pkg::node_feat(n);
            dt_node_cmp #(
                .FEAT_W (FEAT_W),
                .PREC   (dt_pkg::node_prec(n)),
                .THR    (dt_pkg::node_thr(n))
            ) u_cmp (
                .feat    (in_feat[FI*FEAT_W +: FEAT_W]),
                .go_left (go_left[n])
            );
        end
    endgenerate

    dt_leaf_resolve #(
        .NUM_NODES  (NUM_NODES),
        .NUM_LEAVES (NUM_LEAVES),
        .CLASS_W    (CLASS_W)
    ) u_resolve (
        .go_left  (go_left),
        .leaf_hit (leaf_hit),
        .leaf_cls (leaf_cls)
    );

    dt_valid_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_class <= '0;
            out_leaf  <= '0;
        end else if (load_en) begin
            out_class <= leaf_cls;
            out_leaf  <= leaf_hit;
        end
    end
endmodule

// File: rtl/dtree_classifier_chk.sv
module dtree_classifier_chk #(
    parameter int NUM_LEAVES = dt_pkg::DEF_NUM_LEAVES,
    parameter int CLASS_W    = dt_pkg::DEF_CLASS_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [CLASS_W-1:0]    out_class,
    input logic [NUM_LEAVES-1:0] out_leaf
);
    a_r5_single_leaf: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_leaf) == 1));

    a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_class) && $stable(out_leaf)));

    a_r6_label_l3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_leaf[3]) |-> (out_class == CLASS_W'(3)));

    a_r6_label_l5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_leaf[5]) |-> (out_class == CLASS_W'(0)));
endmodule

bind dtree_classifier dtree_classifier_chk #(
    .NUM_LEAVES (NUM_LEAVES),
    .CLASS_W    (CLASS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_class (out_class),
    .out_leaf  (out_leaf)
);

// File: tb/dtree_classifier_test.sv
module dtree_classifier_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_feat = '0;
    logic        out_valid;
    logic [1:0]  out_class;
    logic [6:0]  out_leaf;

    int checks = 0;
    int errors = 0;
    logic [1:0] last_cls = '0;
    logic [6:0] last_leaf = '0;

    always #4 clk = ~clk;

    dtree_classifier uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_feat   (in_feat),
        .out_valid (out_valid),
        .out_class (out_class),
        .out_leaf  (out_leaf)
    );

    // Behavioural walk of the tree table in the brief (R2, R3, R4).
    function automatic int ref_leaf(input logic [7:0] f0, input logic [7:0] f1,
                                    input logic [7:0] f2, input logic [7:0] f3);
        if (f0 <= 8'd100) begin
            if ((f1 >> 4) <= 9) return 0;
            else if ((f3 >> 5) <= 2) return 2;
            else return 3;
        end else if ((f2 >> 2) <= 40) begin
            if ((f0 >> 1) <= 60) return 4;
            else if ((f3 >> 6) <= 1) return 5;
            else return 6;
        end else return 1;
    endfunction

    function automatic logic [1:0] ref_class(input int leaf);
        case (leaf)
            0: return 2'd0; 1: return 2'd1; 2: return 2'd2; 3: return 2'd3;
            4: return 2'd1; 5: return 2'd0; default: return 2'd2;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle; the result is sampled at the following falling edge.
    task automatic step(input logic v, input logic [7:0] f0, input logic [7:0] f1,
                        input logic [7:0] f2, input logic [7:0] f3, input string req);
        int lf;
        in_valid = v;
        in_feat  = {f3, f2, f1, f0};  // R1 packing
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            lf = ref_leaf(f0, f1, f2, f3);
            last_leaf = 7'(1) << lf;
            last_cls  = ref_class(lf);
            check({req, " R7 valid"}, 32'(out_valid), 32'd1);
            check({req, " R4 leaf"}, 32'(out_leaf), 32'(last_leaf));
            check({req, " R6 class"}, 32'(out_class), 32'(last_cls));
            check({req, " R5 onehot"}, 32'($countones(out_leaf)), 32'd1);
        end else begin
            check({req, " R7 idle"}, 32'(out_valid), 32'd0);
            check({req, " R8 hold class"}, 32'(out_class), 32'(last_cls));
            check({req, " R8 hold leaf"}, 32'(out_leaf), 32'(last_leaf));
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 out_valid", 32'(out_valid), 32'd0);
        check("R9 out_class", 32'(out_class), 32'd0);
        check("R9 out_leaf", 32'(out_leaf), 32'd0);

        // R2 / R3 boundaries: truncated value on each threshold and one above
        step(1, 8'd100, 8'd159, 8'd0, 8'd0, "R2 n0 tie n1 tie");
        step(1, 8'd101, 8'd0, 8'd163, 8'd0, "R2 n0 above n2 tie");
        step(1, 8'd100, 8'd160, 8'd0, 8'd95, "R2 n1 above n3 tie");
        step(1, 8'd100, 8'd160, 8'd0, 8'd96, "R2 n3 above");
        step(1, 8'd120, 8'd0, 8'd164, 8'd0, "R2 n2 above");
        step(1, 8'd121, 8'd0, 8'd100, 8'd0, "R3 n4 low bit dropped");
        step(1, 8'd122, 8'd0, 8'd100, 8'd127, "R2 n4 above n5 tie");
        step(1, 8'd122, 8'd0, 8'd100, 8'd128, "R2 n5 above");
        step(1, 8'd100, 8'd144, 8'd0, 8'd64, "R3 n1 low bits dropped");
        step(0, 8'd255, 8'd255, 8'd255, 8'd255, "R8 idle after stream");
        step(0, 8'd0, 8'd0, 8'd0, 8'd0, "R8 second idle");
        step(1, 8'd255, 8'd255, 8'd255, 8'd255, "R4 all ones");
        step(1, 8'd0, 8'd0, 8'd0, 8'd0, "R4 all zeros");

        // Random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), "R4 random");
        end

        // R9 reset during traffic
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid reset valid", 32'(out_valid), 32'd0);
        check("R9 mid reset leaf", 32'(out_leaf), 32'd0);
        rst = 1'b0;
        last_cls = '0;
        last_leaf = '0;
        step(0, 8'd7, 8'd7, 8'd7, 8'd7, "R8 idle after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule